// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Decoder

This block steers a single active-low memory chip-enable onto one of four active-low bank enables, picked by two select inputs, for as long as the supply is good. An external comparator supplies a digital power-fail flag. The block uses that flag to write-protect every bank around a loss of power.

When the flag rises during an access, that access may finish. It is cut off if it runs longer than a bounded timeout. When power returns, all banks stay disabled for a long recovery hold before normal decoding resumes. A threshold-select input carries no control meaning and is only copied to a status output.

The block is a four-state machine: normal decoding, access draining, protected and recovering. One shared cycle counter times both the drain timeout and the recovery hold. Both limits are parameters given in clock cycles. Reset is synchronous and active high, and it puts the block in the protected state.

Top module: `pfg_top`

## Requirements
- R1: While decoding normally, a high `chip_en_n` drives all four bits of `bank_en_n` high, whatever the select inputs are.
- R2: While decoding normally with `chip_en_n` low, exactly one bank enable is low. {`sel_a`,`sel_b`} = 00 lowers bit 0, 01 lowers bit 1, 10 lowers bit 2 and 11 lowers bit 3.
- R3: If `pwr_fail` is sampled high while `chip_en_n` is low, the access in flight continues. The selected bank stays low until `chip_en_n` rises, and every bank is high from that cycle onward.
- R4: A draining access still low after `TIMEOUT_CYC` cycles is cut off. All banks are forced high from the next cycle, even though `chip_en_n` is still low.
- R5: If `pwr_fail` is sampled high while `chip_en_n` is high, the block goes straight to the protected state. From the next cycle, a low `chip_en_n` has no effect on the bank enables.
- R6: While protected, all bank enables stay high regardless of `chip_en_n` and the select inputs.
- R7: Once `pwr_fail` is sampled low in the protected state, all bank enables stay high for `RECOVER_CYC + 1` further clock edges. Decoding resumes after that.
- R8: A `pwr_fail` sampled high during recovery returns the block to the protected state, and the full recovery hold starts again on the next release.
- R9: `wp_stat` is high in every state except normal decoding. Reset leaves the block protected, with `wp_stat` high and all bank enables high.
- R10: `tol_sel_q` repeats `thresh_sel` one clock later, and `thresh_sel` has no effect on the bank enables.
- R11: While decoding normally, a change of the select inputs moves the low bank enable within the same cycle. No clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Active-low chip-enable from the host |
| sel_a | input | 1 | Select input, upper bit of the bank index |
| sel_b | input | 1 | Select input, lower bit of the bank index |
| pwr_fail | input | 1 | High while the supply is below threshold |
| thresh_sel | input | 1 | Threshold choice, status only |
| bank_en_n | output | 4 | Active-low bank enables, bit 0 is the first bank |
| wp_stat | output | 1 | High when the banks are write-protected |
| tol_sel_q | output | 1 | Registered copy of `thresh_sel` |

## Verification
The assertions assume that `pwr_fail` and `chip_en_n` are already synchronous to `clk`, so a level seen at one edge is the level the state machine acts on. They also assume that reset is held for at least two edges, so that history checks never reach before reset. The stimulus changes every input two time units after a rising edge, keeps reset high for three edges, and uses small timeout and recovery limits, so that the drain cut-off and a recovery restart both fall inside short directed sequences.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        ST_VALID = 2'd0,
        ST_DRAIN = 2'd1,
        ST_PROT  = 2'd2,
        ST_RECOV = 2'd3
    } pfg_state_e;

    typedef struct packed {
        logic       ce_n;
        logic [1:0] sel;
    } pfg_req_t;

    function automatic int unsigned pfg_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic pfg_passes(input pfg_state_e st);
        return (st == ST_VALID) || (st == ST_DRAIN);
    endfunction

endpackage

// File: rtl/pfg_timer.sv
module pfg_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
    import pfg_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 8,
    parameter int unsigned RECOVER_CYC = 20,
    parameter int unsigned CNT_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_fail,
    input  logic             ce_n,
    input  logic [CNT_W-1:0] count,
    output pfg_state_e       state,
    output logic             tmr_clr,
    output logic             tmr_inc
);
    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] RC_LAST = CNT_W'(RECOVER_CYC - 1);

    pfg_state_e nxt;

    always_comb begin
        nxt     = state;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        unique case (state)
            ST_VALID: begin
                tmr_clr = 1'b1;
                if (pwr_fail) begin
                    nxt = ce_n ? ST_PROT : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (ce_n || (count == TO_LAST)) begin
                    nxt     = ST_PROT;
                    tmr_clr = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_PROT: begin
                tmr_clr = 1'b1;
                if (!pwr_fail) begin
                    nxt = ST_RECOV;
                end
            end
            ST_RECOV: begin
                if (pwr_fail) begin
                    nxt     = ST_PROT;
                    tmr_clr = 1'b1;
                end else if (count == RC_LAST) begin
                    nxt     = ST_VALID;
                    tmr_clr = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            default: begin
                nxt     = ST_PROT;
                tmr_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PROT;
        end else begin
            state <= nxt;
        end
    end

    // R3: draining is only entered from normal decoding with an access low
    p_drain_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && $past(state) != ST_DRAIN)
            |-> ($past(state) == ST_VALID && !$past(ce_n) && $past(pwr_fail)));

    // R4: the drain window never outlasts the timeout
    p_drain_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> (count < CNT_W'(TIMEOUT_CYC)));

    // R5: a failure seen with no access pending skips the drain phase
    p_direct_prot_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VALID && pwr_fail && ce_n) |=> (state == ST_PROT));

    // R7: normal decoding resumes only from a completed recovery
    p_valid_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VALID && $past(state) != ST_VALID)
            |-> ($past(state) == ST_RECOV && $past(count) == RC_LAST && !$past(pwr_fail)));

    // R8: a failure during recovery falls back to protection
    p_reassert_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOV && pwr_fail) |=> (state == ST_PROT));
endmodule

// File: rtl/pfg_decode.sv
module pfg_decode
    import pfg_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  pfg_req_t                req,
    input  logic                    pass,
    output logic [(1<<SEL_W)-1:0]   bank_n
);
    localparam int unsigned NBANK = 1 << SEL_W;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_comb begin
            bank_n[g] = !(pass && !req.ce_n && (req.sel == SEL_W'(g)));
        end
    end
endmodule

// File: rtl/pfg_top.sv
module pfg_top
    import pfg_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 10000,
    parameter int unsigned RECOVER_CYC = 8000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_en_n,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       pwr_fail,
    input  logic       thresh_sel,
    output logic [3:0] bank_en_n,
    output logic       wp_stat,
    output logic       tol_sel_q
);
    localparam int unsigned SEL_W = 2;
    localparam int unsigned CNT_W = $clog2(pfg_max(TIMEOUT_CYC, RECOVER_CYC) + 1);

    pfg_state_e       state;
    logic [CNT_W-1:0] count;
    logic             tmr_clr;
    logic             tmr_inc;
    pfg_req_t         req;

    assign req.ce_n = chip_en_n;
    assign req.sel  = {sel_a, sel_b};

    pfg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .count (count)
    );

    pfg_fsm #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .RECOVER_CYC (RECOVER_CYC),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwr_fail (pwr_fail),
        .ce_n     (chip_en_n),
        .count    (count),
        .state    (state),
        .tmr_clr  (tmr_clr),
        .tmr_inc  (tmr_inc)
    );

    pfg_decode #(.SEL_W(SEL_W)) u_decode (
        .req    (req),
        .pass   (pfg_passes(state)),
        .bank_n (bank_en_n)
    );

    assign wp_stat = (state != ST_VALID);

    always_ff @(posedge clk) begin
        if (rst) begin
            tol_sel_q <= 1'b0;
        end else begin
            tol_sel_q <= thresh_sel;
        end
    end

    // R1: an idle chip-enable never opens a bank
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        chip_en_n |-> (&bank_en_n));

    // R2: exactly one bank opens for an access during normal decoding
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        (!wp_stat && !chip_en_n) |-> ($countones(~bank_en_n) == 1));

    // R6: protected and recovering states keep every bank closed
    p_prot_high_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROT || state == ST_RECOV) |-> (&bank_en_n));

    // R10: the status copy follows its input by one clock
    p_tol_track_r10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (tol_sel_q == $past(thresh_sel)));
endmodule

// File: tb/pfg_top_tb.sv
module pfg_top_tb;
    localparam int unsigned TO = 8;
    localparam int unsigned RC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_en_n = 1'b1;
    logic       sel_a = 1'b0;
    logic       sel_b = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       thresh_sel = 1'b0;
    logic [3:0] bank_en_n;
    logic       wp_stat;
    logic       tol_sel_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pfg_top #(.TIMEOUT_CYC(TO), .RECOVER_CYC(RC)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .chip_en_n  (chip_en_n),
        .sel_a      (sel_a),
        .sel_b      (sel_b),
        .pwr_fail   (pwr_fail),
        .thresh_sel (thresh_sel),
        .bank_en_n  (bank_en_n),
        .wp_stat    (wp_stat),
        .tol_sel_q  (tol_sel_q)
    );

    // {ce_n, sel_a, sel_b, expected bank_en_n[3:0]}
    localparam logic [6:0] VEC [0:8] = '{
        {3'b000, 4'b1110},
        {3'b001, 4'b1101},
        {3'b010, 4'b1011},
        {3'b011, 4'b0111},
        {3'b100, 4'b1111},
        {3'b111, 4'b1111},
        {3'b101, 4'b1111},
        {3'b011, 4'b0111},
        {3'b000, 4'b1110}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R9 reset banks", bank_en_n, 4'b1111);
        chk("R9 reset wp", {3'b0, wp_stat}, 4'b0001);
        rst = 1'b0;
        chip_en_n = 1'b0;
        tick(RC);
        chk("R7 hold after power-up", bank_en_n, 4'b1111);
        chk("R9 wp during recovery", {3'b0, wp_stat}, 4'b0001);
        tick(1);
        chk("R7 decoding resumes", bank_en_n, 4'b1110);
        chk("R9 wp clear when valid", {3'b0, wp_stat}, 4'b0000);

        for (int i = 0; i < 9; i++) begin
            {chip_en_n, sel_a, sel_b} = VEC[i][6:4];
            #1;
            // R1 R2 R11: same-cycle decode from the current inputs
            chk($sformatf("R1/R2/R11 vector %0d", i), bank_en_n, VEC[i][3:0]);
        end

        chip_en_n = 1'b0; {sel_a, sel_b} = 2'b01; thresh_sel = 1'b1;
        tick(1);
        chk("R10 status copy", {3'b0, tol_sel_q}, 4'b0001);
        chk("R10 no effect on banks", bank_en_n, 4'b1101);
        thresh_sel = 1'b0;
        tick(1);
        chk("R10 status copy low", {3'b0, tol_sel_q}, 4'b0000);

        // R3: access in flight completes
        {sel_a, sel_b} = 2'b10; pwr_fail = 1'b1;
        tick(1);
        chk("R3 access continues", bank_en_n, 4'b1011);
        chk("R9 wp while draining", {3'b0, wp_stat}, 4'b0001);
        tick(2);
        chk("R3 access still open", bank_en_n, 4'b1011);
        chip_en_n = 1'b1; #1;
        chk("R3 access ended", bank_en_n, 4'b1111);
        tick(1);
        chip_en_n = 1'b0; #1;
        chk("R6 protected ignores ce", bank_en_n, 4'b1111);

        // R8: failure during recovery restarts the hold
        pwr_fail = 1'b0; {sel_a, sel_b} = 2'b00;
        tick(6);
        chk("R7 recovering", bank_en_n, 4'b1111);
        pwr_fail = 1'b1;
        tick(1);
        pwr_fail = 1'b0;
        tick(RC);
        chk("R8 full hold restarted", bank_en_n, 4'b1111);
        tick(1);
        chk("R8 decoding after restarted hold", bank_en_n, 4'b1110);

        // R4: drain timeout
        pwr_fail = 1'b1;
        tick(1);
        tick(TO - 1);
        chk("R4 before timeout", bank_en_n, 4'b1110);
        tick(1);
        chk("R4 cut off at timeout", bank_en_n, 4'b1111);

        // R5: failure with idle chip-enable
        pwr_fail = 1'b0;
        tick(RC + 1);
        chk("R7 valid again", bank_en_n, 4'b1110);
        chip_en_n = 1'b1; pwr_fail = 1'b1;
        tick(1);
        chip_en_n = 1'b0; #1;
        chk("R5 direct protect", bank_en_n, 4'b1111);
        chk("R5 wp set", {3'b0, wp_stat}, 4'b0001);
        tick(3);
        chk("R6 still protected", bank_en_n, 4'b1111);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule